// File: doc/BRIEF.md
# Counter-Mode Keystream Combiner

This block drives counter-mode encryption around an external block cipher. It keeps a 128-bit counter as a little-endian integer. On a start command it issues one batch of eight cipher requests. Each request carries the next counter value with its sixteen bytes mirrored end for end. The block XORs each returned cipher word with the source word that pairs with it and emits the result as a destination word.

At the end of a batch the stored counter has moved on by eight, so the next start carries on from there without software touching it. A load command seeds the counter while the block is idle. The cipher is reached over two valid/ready channels, one for requests and one for responses. Each response is accepted only in the same cycle as a source word, so the two streams stay paired in counter order.

Top module: `ctr_keystream_gen`

## Requirements
- R1: While reset is asserted, `busy_o`, `batch_done_o`, `cip_req_valid_o` and `dst_valid_o` are 0 and `ctr_o` reads all zeros.
- R2: A `load_i` in an idle cycle makes `ctr_o` equal `load_ctr_i` from the next cycle. A `load_i` while `busy_o` is high changes nothing.
- R3: Request data is the working counter with its bytes mirrored: bits [8k+7:8k] of `cip_req_data_o` equal bits [8(15-k)+7:8(15-k)] of the counter, for k = 0..15. A stalled request holds its data.
- R4: A start in an idle cycle without a load raises `busy_o`. The block then issues exactly eight requests, for counter values start, start+1, ... start+7, in that order. `cip_req_valid_o` is low whenever the block is idle or all eight requests have been accepted.
- R5: In the cycle after a response is accepted, `dst_valid_o` is 1 and `dst_data_o` equals that response XOR the source word accepted with it. In every other cycle `dst_valid_o` is 0.
- R6: After the eighth response, and once all eight requests are out, `busy_o` falls. `batch_done_o` is then high for exactly one cycle, and in that same cycle `ctr_o` equals the batch's start value plus eight.
- R7: The increment is a full 128-bit add. A carry out of bit 63 reaches bit 64.
- R8: The counter wraps modulo 2^128 with no indication.
- R9: A start while `busy_o` is high is ignored. `ctr_o` does not change during a batch except at its end.
- R10: A response and a source word are accepted only together. `cip_rsp_ready_o` is high exactly when the block is busy, fewer than eight responses have been taken, and `src_valid_i` is high. `src_ready_o` follows the same rule with `cip_rsp_valid_i` in place of `src_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Seed the counter (idle only) |
| load_ctr_i | input | 128 | Little-endian seed value |
| start_i | input | 1 | Begin one batch of eight |
| ctr_o | output | 128 | Stored counter |
| busy_o | output | 1 | Batch in progress |
| batch_done_o | output | 1 | One-cycle pulse at batch end |
| cip_req_valid_o | output | 1 | Cipher request valid |
| cip_req_ready_i | input | 1 | Cipher request ready |
| cip_req_data_o | output | 128 | Byte-mirrored counter value |
| cip_rsp_valid_i | input | 1 | Cipher response valid |
| cip_rsp_ready_o | output | 1 | Cipher response ready |
| cip_rsp_data_i | input | 128 | Encrypted counter |
| src_valid_i | input | 1 | Source word valid |
| src_ready_o | output | 1 | Source word taken |
| src_data_i | input | 128 | Source word |
| dst_valid_o | output | 1 | Destination word valid |
| dst_data_o | output | 128 | Source XOR encrypted counter |

## Verification
The ready and valid outputs and the request data are combinational, so they are due in the same cycle as the inputs that drive them. The bench checks them one time unit after it drives new inputs, before the next rising edge. Destination words, `busy_o`, `batch_done_o` and `ctr_o` are registered and due one edge after the handshake or command that causes them. The reference model records its expectation at the moment that handshake or command is seen, and compares it at the following falling edge. Seeds just below the 64-bit boundary and just below 2^128 exercise the carry and the wrap. Random stalls on every channel shift where each result lands in time.

// File: rtl/ctr_ks_pkg.sv
package ctr_ks_pkg;
  localparam int unsigned BLK_W  = 128;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = BLK_W / BYTE_W;

  typedef logic [BLK_W-1:0] blk_t;

  // Full byte mirror: output byte k takes input byte NBYTES-1-k.
  function automatic blk_t byte_mirror(input blk_t v);
    blk_t r;
    for (int k = 0; k < int'(NBYTES); k++) begin
      r[k*BYTE_W +: BYTE_W] = v[(int'(NBYTES) - 1 - k)*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/ctr_ks_incr.sv
// Segmented +1 adder; carry ripples from each segment into the next.
module ctr_ks_incr #(
  parameter int unsigned W     = 128,
  parameter int unsigned SEG_W = 64
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] sum_o
);
  localparam int unsigned NSEG = W / SEG_W;

  logic [NSEG-1:0] carry;
  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == NSEG - 1) begin : g_top
      assign sum_o[g*SEG_W +: SEG_W] = val_i[g*SEG_W +: SEG_W] + {{(SEG_W-1){1'b0}}, carry[g]};
    end else begin : g_mid
      assign {carry[g+1], sum_o[g*SEG_W +: SEG_W]} =
        {1'b0, val_i[g*SEG_W +: SEG_W]} + {{SEG_W{1'b0}}, carry[g]};
    end
  end
endmodule

// File: rtl/ctr_ks_issue.sv
// Request side: walks the working counter and issues mirrored values.
module ctr_ks_issue
  import ctr_ks_pkg::*;
#(
  parameter int unsigned BATCH = 8,
  parameter int unsigned SEG_W = 64,
  localparam int unsigned CNT_W = $clog2(BATCH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic launch_i,
  input  blk_t seed_i,
  input  logic req_ready_i,
  output logic req_valid_o,
  output blk_t req_data_o,
  output blk_t work_o,
  output logic all_issued_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BATCH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  blk_t             work_q, work_d, work_inc;
  logic             fire, upd;

  ctr_ks_incr #(.W(BLK_W), .SEG_W(SEG_W)) u_incr (
    .val_i (work_q),
    .sum_o (work_inc)
  );

  assign all_issued_o = (cnt_q == LAST);
  assign req_valid_o  = active_i && !all_issued_o;
  assign fire         = req_valid_o && req_ready_i;
  assign req_data_o   = byte_mirror(work_q);
  assign work_o       = work_q;
  assign upd          = launch_i || fire;

  always_comb begin
    cnt_d  = cnt_q;
    work_d = work_q;
    if (launch_i) begin
      cnt_d  = '0;
      work_d = seed_i;
    end else if (fire) begin
      cnt_d  = cnt_q + CNT_W'(1);
      work_d = work_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      work_q <= '0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      work_q <= work_d;
    end
  end
endmodule

// File: rtl/ctr_ks_combine.sv
// Response side: joins each cipher word with a source word and XORs them.
module ctr_ks_combine
  import ctr_ks_pkg::*;
#(
  parameter int unsigned BATCH = 8,
  localparam int unsigned CNT_W = $clog2(BATCH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic launch_i,
  input  logic rsp_valid_i,
  input  blk_t rsp_data_i,
  input  logic src_valid_i,
  input  blk_t src_data_i,
  output logic rsp_ready_o,
  output logic src_ready_o,
  output logic dst_valid_o,
  output blk_t dst_data_o,
  output logic all_done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BATCH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             room, join_fire, dv_q;
  blk_t             dd_q;

  assign all_done_o  = (cnt_q == LAST);
  assign room        = active_i && !all_done_o;
  assign rsp_ready_o = room && src_valid_i;
  assign src_ready_o = room && rsp_valid_i;
  assign join_fire   = room && rsp_valid_i && src_valid_i;

  always_comb begin
    cnt_d = cnt_q;
    if (launch_i)       cnt_d = '0;
    else if (join_fire) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dv_q  <= 1'b0;
      dd_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      dv_q  <= join_fire;
      if (join_fire) dd_q <= rsp_data_i ^ src_data_i;
    end
  end

  assign dst_valid_o = dv_q;
  assign dst_data_o  = dd_q;
endmodule

// File: rtl/ctr_keystream_gen.sv
module ctr_keystream_gen
  import ctr_ks_pkg::*;
#(
  parameter int unsigned BATCH = 8,
  parameter int unsigned SEG_W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [127:0] load_ctr_i,
  input  logic         start_i,
  output logic [127:0] ctr_o,
  output logic         busy_o,
  output logic         batch_done_o,
  output logic         cip_req_valid_o,
  input  logic         cip_req_ready_i,
  output logic [127:0] cip_req_data_o,
  input  logic         cip_rsp_valid_i,
  output logic         cip_rsp_ready_o,
  input  logic [127:0] cip_rsp_data_i,
  input  logic         src_valid_i,
  output logic         src_ready_o,
  input  logic [127:0] src_data_i,
  output logic         dst_valid_o,
  output logic [127:0] dst_data_o
);
  logic busy_q, busy_d, done_q;
  blk_t ctr_q, ctr_d, work;
  logic launch, finish, load_en, ctr_en, all_issued, all_done;

  assign launch  = start_i && !load_i && !busy_q;
  assign load_en = load_i && !busy_q;
  assign finish  = busy_q && all_issued && all_done;
  assign ctr_en  = load_en || finish;

  ctr_ks_issue #(.BATCH(BATCH), .SEG_W(SEG_W)) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .active_i     (busy_q),
    .launch_i     (launch),
    .seed_i       (ctr_q),
    .req_ready_i  (cip_req_ready_i),
    .req_valid_o  (cip_req_valid_o),
    .req_data_o   (cip_req_data_o),
    .work_o       (work),
    .all_issued_o (all_issued)
  );

  ctr_ks_combine #(.BATCH(BATCH)) u_combine (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (busy_q),
    .launch_i    (launch),
    .rsp_valid_i (cip_rsp_valid_i),
    .rsp_data_i  (cip_rsp_data_i),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .rsp_ready_o (cip_rsp_ready_o),
    .src_ready_o (src_ready_o),
    .dst_valid_o (dst_valid_o),
    .dst_data_o  (dst_data_o),
    .all_done_o  (all_done)
  );

  always_comb begin
    busy_d = busy_q;
    if (launch)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    ctr_d = finish ? work : load_ctr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ctr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= finish;
      if (ctr_en) ctr_q <= ctr_d;
    end
  end

  assign busy_o       = busy_q;
  assign batch_done_o = done_q;
  assign ctr_o        = ctr_q;
endmodule

// File: rtl/ctr_keystream_gen_chk.sv
module ctr_keystream_gen_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         load_i,
  input logic [127:0] load_ctr_i,
  input logic         start_i,
  input logic [127:0] ctr_o,
  input logic         busy_o,
  input logic         batch_done_o,
  input logic         cip_req_valid_o,
  input logic         cip_req_ready_i,
  input logic [127:0] cip_req_data_o,
  input logic         cip_rsp_valid_i,
  input logic         cip_rsp_ready_o,
  input logic         src_valid_i,
  input logic         src_ready_o,
  input logic         dst_valid_o
);
  assert_idle_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cip_req_valid_o);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cip_req_valid_o && !cip_req_ready_i |=> cip_req_valid_o && $stable(cip_req_data_o));

  assert_paired_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cip_rsp_valid_i && cip_rsp_ready_o |-> src_valid_i && src_ready_o);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done_o |-> !busy_o ##1 !batch_done_o);

  assert_load_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !busy_o |=> ctr_o == $past(load_ctr_i));

  assert_ctr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> batch_done_o || $stable(ctr_o));

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !load_i && !busy_o |=> busy_o);

  assert_dst_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cip_rsp_valid_i && cip_rsp_ready_o) |=> dst_valid_o);

  assert_dst_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cip_rsp_valid_i && cip_rsp_ready_o) |=> !dst_valid_o);
endmodule

bind ctr_keystream_gen ctr_keystream_gen_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .load_i          (load_i),
  .load_ctr_i      (load_ctr_i),
  .start_i         (start_i),
  .ctr_o           (ctr_o),
  .busy_o          (busy_o),
  .batch_done_o    (batch_done_o),
  .cip_req_valid_o (cip_req_valid_o),
  .cip_req_ready_i (cip_req_ready_i),
  .cip_req_data_o  (cip_req_data_o),
  .cip_rsp_valid_i (cip_rsp_valid_i),
  .cip_rsp_ready_o (cip_rsp_ready_o),
  .src_valid_i     (src_valid_i),
  .src_ready_o     (src_ready_o),
  .dst_valid_o     (dst_valid_o)
);

// File: tb/ctr_keystream_gen_tb.sv
module ctr_keystream_gen_tb;
  localparam int BATCH = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i, start_i;
  logic [127:0] load_ctr_i;
  logic [127:0] ctr_o;
  logic         busy_o, batch_done_o;
  logic         cip_req_valid_o, cip_req_ready_i;
  logic [127:0] cip_req_data_o;
  logic         cip_rsp_valid_i, cip_rsp_ready_o;
  logic [127:0] cip_rsp_data_i;
  logic         src_valid_i, src_ready_o;
  logic [127:0] src_data_i;
  logic         dst_valid_o;
  logic [127:0] dst_data_o;

  always #4 clk = ~clk;

  ctr_keystream_gen u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_ctr_i(load_ctr_i),
    .start_i(start_i), .ctr_o(ctr_o), .busy_o(busy_o), .batch_done_o(batch_done_o),
    .cip_req_valid_o(cip_req_valid_o), .cip_req_ready_i(cip_req_ready_i),
    .cip_req_data_o(cip_req_data_o), .cip_rsp_valid_i(cip_rsp_valid_i),
    .cip_rsp_ready_o(cip_rsp_ready_o), .cip_rsp_data_i(cip_rsp_data_i),
    .src_valid_i(src_valid_i), .src_ready_o(src_ready_o), .src_data_i(src_data_i),
    .dst_valid_o(dst_valid_o), .dst_data_o(dst_data_o)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [127:0] m_ctr, m_work, exp_dd;
  bit           m_busy, exp_dv, exp_done;
  int           m_iss, m_rsp, src_idx;
  logic [127:0] enc_q[$];
  // Stimulus requests from the sequencer
  bit           want_load, want_start;
  logic [127:0] want_val;
  int           mode;
  logic [15:0]  lfsr;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mirror_ref(input logic [127:0] v);
    logic [127:0] r = '0;
    logic [127:0] t = v;
    for (int i = 0; i < 16; i++) begin
      r = (r << 8) | {120'd0, t[7:0]};
      t = t >> 8;
    end
    return r;
  endfunction

  function automatic logic [127:0] fake_enc(input logic [127:0] x);
    return {x[63:0], x[127:64]} ^ 128'h5A3C_96E1_0F87_D2B4_C3A5_1E69_7B0D_F248;
  endfunction

  function automatic logic [127:0] src_word(input int n);
    logic [31:0] w = 32'h9E37_79B9 * (n + 1);
    return {w, ~w, w ^ 32'h1234_5678, w + 32'd7};
  endfunction

  task automatic step();
    bit done_now, load_now, launch_now, req_exp, room;
    if (!rst_n) begin
      m_ctr = '0; m_work = '0; m_busy = 0; exp_dv = 0; exp_done = 0;
      m_iss = 0; m_rsp = 0; enc_q.delete();
      load_i = 0; start_i = 0; load_ctr_i = '0;
      cip_req_ready_i = 0; cip_rsp_valid_i = 0; cip_rsp_data_i = '0;
      src_valid_i = 0; src_data_i = '0;
      return;
    end
    // Registered outputs due from the previous edge
    chk("R5 dst_valid", {127'd0, dst_valid_o}, {127'd0, exp_dv});
    if (exp_dv) chk("R5 dst_data", dst_data_o, exp_dd);
    chk("R6 batch_done", {127'd0, batch_done_o}, {127'd0, exp_done});
    chk("R2 ctr_o", ctr_o, m_ctr);
    chk("R4 busy", {127'd0, busy_o}, {127'd0, m_busy});
    // Drive the next cycle's inputs
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    load_i     = want_load;  load_ctr_i = want_val; want_load = 0;
    start_i    = want_start; want_start = 0;
    cip_req_ready_i = (mode == 0) ? 1'b1 : lfsr[0];
    cip_rsp_valid_i = (enc_q.size() > 0) && ((mode == 0) || lfsr[3]);
    cip_rsp_data_i  = (enc_q.size() > 0) ? enc_q[0] : '0;
    src_valid_i     = (mode == 0) || lfsr[6];
    src_data_i      = src_word(src_idx);
    #1;
    // Combinational outputs and model update for the coming edge
    done_now   = m_busy && m_iss == BATCH && m_rsp == BATCH;
    load_now   = !m_busy && load_i;
    launch_now = !m_busy && start_i && !load_i;
    req_exp    = m_busy && m_iss < BATCH;
    room       = m_busy && m_rsp < BATCH;
    chk("R4 req_valid", {127'd0, cip_req_valid_o}, {127'd0, req_exp});
    chk("R10 rsp_ready", {127'd0, cip_rsp_ready_o}, {127'd0, room && src_valid_i});
    chk("R10 src_ready", {127'd0, src_ready_o}, {127'd0, room && cip_rsp_valid_i});
    if (cip_req_valid_o && cip_req_ready_i) begin
      chk("R3 req_data", cip_req_data_o, mirror_ref(m_work));
      enc_q.push_back(fake_enc(mirror_ref(m_work)));
      m_work = m_work + 128'd1;
      m_iss++;
    end
    exp_dv = cip_rsp_valid_i && cip_rsp_ready_o;
    if (exp_dv) begin
      exp_dd = cip_rsp_data_i ^ src_data_i;
      void'(enc_q.pop_front());
      src_idx++;
      m_rsp++;
    end
    exp_done = done_now;
    if (done_now) begin m_busy = 0; m_ctr = m_work; end
    if (load_now) m_ctr = load_ctr_i;
    if (launch_now) begin m_busy = 1; m_work = m_ctr; m_iss = 0; m_rsp = 0; end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      step();
    end
  end

  task automatic do_load(input logic [127:0] v);
    want_val = v; want_load = 1;
    @(negedge clk); #2;
    @(negedge clk); #2;
  endtask

  task automatic run_batch();
    want_start = 1;
    @(negedge clk); #2;
    while (m_busy || want_start) begin @(negedge clk); #2; end
    repeat (2) @(negedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst_n = 0; mode = 0; lfsr = 16'hACE1; src_idx = 0;
    want_load = 0; want_start = 0; want_val = '0;
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    chk("R1 busy", {127'd0, busy_o}, 128'd0);
    chk("R1 batch_done", {127'd0, batch_done_o}, 128'd0);
    chk("R1 req_valid", {127'd0, cip_req_valid_o}, 128'd0);
    chk("R1 dst_valid", {127'd0, dst_valid_o}, 128'd0);
    chk("R1 ctr_o", ctr_o, 128'd0);
    @(posedge clk); #1 rst_n = 1;
    repeat (2) @(negedge clk);
    #2;

    // R2/R6: seeded batch, no stalls
    do_load(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    chk("R2 loaded", ctr_o, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    run_batch();
    chk("R6 plus eight", ctr_o, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3218);

    // R6: back-to-back batch with random stalls continues from stored value
    mode = 1;
    run_batch();
    chk("R6 second batch", ctr_o, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3220);

    // R7: carry across the 64-bit boundary
    do_load(128'h0000_0000_0000_0007_FFFF_FFFF_FFFF_FFFC);
    run_batch();
    chk("R7 carry", ctr_o, 128'h0000_0000_0000_0008_0000_0000_0000_0004);

    // R8: wrap modulo 2^128
    do_load(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFD);
    run_batch();
    chk("R8 wrap", ctr_o, 128'h0000_0000_0000_0000_0000_0000_0000_0005);

    // R2/R9: load and start while busy are ignored
    want_start = 1;
    @(negedge clk); #2;
    @(negedge clk); #2;
    want_val = 128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF; want_load = 1;
    @(negedge clk); #2;
    chk("R2 load while busy", ctr_o, 128'h5);
    want_start = 1;
    @(negedge clk); #2;
    while (m_busy) begin @(negedge clk); #2; end
    repeat (2) @(negedge clk);
    #2;
    chk("R9 single batch", ctr_o, 128'hD);
    chk("R9 idle after", {127'd0, busy_o}, 128'd0);

    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule